// File: doc/BRIEF.md
# Dual-Lane Reversible Column Driver Core

This block is the logic core of a 64-channel display column driver. Serial pixel data enters on two lanes at once, and both lanes advance on the same clock edge. Each lane is a 32-stage shift chain. A direction input sets which way data travels through the chains. It also sets which end pin of each lane receives data and which end pin forwards data to the next device in a cascade.

A bank of output holding registers sits between the chains and the 64 channel enables. While the load input is high, the bank tracks the chain contents. While it is low, the bank keeps the last captured frame, so the next frame can be shifted in without disturbing the display. An active-low blank input turns every channel on, whatever the bank holds.

Each lane has two end pins, the low end and the high end. Each end pin is modelled as an input, an output and an output enable.

Top module: `dlr_column_driver`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears every chain stage and every holding register to 0. After reset, with blank_n high, chan_on is all zeros and both serial outputs of both lanes read 0.
- R2: With dir_cw = 1, at each rising edge stage i+1 of lane k takes the old stage i, and stage 0 takes lo_pin_in[k]. Stage i of lane k feeds channel k*32+i.
- R3: With dir_cw = 0, at each rising edge stage i of lane k takes the old stage i+1, and stage 31 takes hi_pin_in[k].
- R4: With dir_cw = 1, hi_pin_oe is 2'b11 and lo_pin_oe is 2'b00. With dir_cw = 0, lo_pin_oe is 2'b11 and hi_pin_oe is 2'b00.
- R5: hi_pin_out[k] always shows stage 31 of lane k, and lo_pin_out[k] always shows stage 0 of lane k, so the enabled pin carries the last stage in the current direction.
- R6: Chain shifting gives the same result whatever latch_en and blank_n do during the shift.
- R7: At a rising edge with latch_en high, the holding bank captures the chain contents present just before that edge. With latch_en low, the bank keeps its value while the chains keep shifting.
- R8: With blank_n low, all 64 bits of chan_on are 1. With blank_n high, chan_on equals the holding bank.
- R9: The two lanes carry independent data in the same cycles: lane 0 drives chan_on[31:0] and lane 1 drives chan_on[63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_cw | input | 1 | 1: shift toward higher channels; 0: toward lower channels |
| latch_en | input | 1 | Holding bank tracks the chains while high |
| blank_n | input | 1 | Low forces all channels on |
| lo_pin_in | input | 2 | Low-end pin input per lane (serial in when dir_cw = 1) |
| lo_pin_out | output | 2 | Low-end pin output per lane (stage 0) |
| lo_pin_oe | output | 2 | Low-end pin output enable per lane |
| hi_pin_in | input | 2 | High-end pin input per lane (serial in when dir_cw = 0) |
| hi_pin_out | output | 2 | High-end pin output per lane (stage 31) |
| hi_pin_oe | output | 2 | High-end pin output enable per lane |
| chan_on | output | 64 | Channel enables, bit n is channel n |

## Verification
A table of frames is shifted into both lanes in each direction. The frames are all-ones, alternating bits, a walking pattern and unrelated words on the two lanes. These separate a reversed or swapped lane, a stage offset by one, and a wrong pin feeding the chain. The serial outputs are sampled before and after one extra shift, which shows that they carry the true end stage in each direction. Directed cases cover these points:
- the frame held while a new frame is shifted in;
- the one-clock lag of the transparent bank;
- shifting under active blank and load;
- blank overriding the held data;
- reset in the middle of a run.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
   typedef enum logic {
      DIR_CCW = 1'b0,
      DIR_CW  = 1'b1
   } shift_dir_e;
endpackage

// File: rtl/dlr_shift_lane.sv
module dlr_shift_lane
   import dlr_pkg::*;
#(
   parameter int STAGES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  shift_dir_e        dir,
   input  logic              lo_in,
   input  logic              hi_in,
   output logic [STAGES-1:0] q
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dlr_shift_lane: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (dir == DIR_CW)
         q <= {q[TOP-1:0], lo_in};
      else
         q <= {hi_in, q[TOP:1]};
   end

   // R1: reset clears the chain
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> q == '0);

   // R2: upward shift, low pin feeds stage 0
   p_cw_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_CW) |=> (q[TOP:1] == $past(q[TOP-1:0])) && (q[0] == $past(lo_in)));

   // R3: downward shift, high pin feeds the top stage
   p_ccw_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_CCW) |=> (q[TOP-1:0] == $past(q[TOP:1])) && (q[TOP] == $past(hi_in)));
endmodule

// File: rtl/dlr_hold_bank.sv
module dlr_hold_bank #(
   parameter int BITS = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] d,
   output logic [BITS-1:0] q
);
   if (BITS < 1) begin : g_bad_bits
      $error("dlr_hold_bank: BITS must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

   // R1: reset clears the bank
   p_bank_reset_r1: assert property (@(posedge clk)
      !rst_n |=> q == '0);

   // R7: capture pre-edge chain contents while loading
   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));

   // R7: hold while not loading
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/dlr_blank_gate.sv
module dlr_blank_gate #(
   parameter int BITS = 64
) (
   input  logic            blank_n,
   input  logic [BITS-1:0] held,
   output logic [BITS-1:0] chan_on
);
   always_comb begin
      chan_on = held;
      if (!blank_n)
         chan_on = '1;
   end
endmodule

// File: rtl/dlr_column_driver.sv
module dlr_column_driver
   import dlr_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dir_cw,
   input  logic                     latch_en,
   input  logic                     blank_n,
   input  logic [LANES-1:0]         lo_pin_in,
   output logic [LANES-1:0]         lo_pin_out,
   output logic [LANES-1:0]         lo_pin_oe,
   input  logic [LANES-1:0]         hi_pin_in,
   output logic [LANES-1:0]         hi_pin_out,
   output logic [LANES-1:0]         hi_pin_oe,
   output logic [LANES*LANE_W-1:0]  chan_on
);
   localparam int CHANS = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("dlr_column_driver: LANES must be positive");
   end

   shift_dir_e           dir_sel;
   logic [CHANS-1:0]     chain_flat;
   logic [CHANS-1:0]     held;

   assign dir_sel = dir_cw ? DIR_CW : DIR_CCW;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] stages;

      dlr_shift_lane #(.STAGES(LANE_W)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .dir   (dir_sel),
         .lo_in (lo_pin_in[k]),
         .hi_in (hi_pin_in[k]),
         .q     (stages)
      );

      assign chain_flat[k*LANE_W +: LANE_W] = stages;
      assign lo_pin_out[k] = stages[0];
      assign hi_pin_out[k] = stages[LANE_W-1];
      assign lo_pin_oe[k]  = (dir_sel == DIR_CCW);
      assign hi_pin_oe[k]  = (dir_sel == DIR_CW);
   end

   dlr_hold_bank #(.BITS(CHANS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (latch_en),
      .d     (chain_flat),
      .q     (held)
   );

   dlr_blank_gate #(.BITS(CHANS)) u_blank (
      .blank_n (blank_n),
      .held    (held),
      .chan_on (chan_on)
   );

   // R8: blank forces every channel on
   p_blank_all_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> &chan_on);

   // R8: unblanked channels follow the bank
   p_unblank_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blank_n |-> chan_on == held);
endmodule

// File: tb/tb_dlr_column_driver.sv
`timescale 1ns/1ps
module tb_dlr_column_driver;
   typedef struct packed {
      logic        dir;
      logic [31:0] d1;
      logic [31:0] d0;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{1'b1, 32'h5555_5555, 32'hAAAA_AAAA},
      '{1'b1, 32'h0000_0001, 32'h8000_0000},
      '{1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
      '{1'b0, 32'h8000_0001, 32'h0000_0003},
      '{1'b0, 32'hC0FF_EE11, 32'h0F0F_0F0F}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_cw = 1'b1;
   logic        latch_en = 1'b0;
   logic        blank_n = 1'b1;
   logic [1:0]  lo_pin_in = 2'b00;
   logic [1:0]  hi_pin_in = 2'b00;
   logic [1:0]  lo_pin_out, lo_pin_oe, hi_pin_out, hi_pin_oe;
   logic [63:0] chan_on;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dlr_column_driver dut (
      .clk(clk), .rst_n(rst_n), .dir_cw(dir_cw), .latch_en(latch_en),
      .blank_n(blank_n), .lo_pin_in(lo_pin_in), .lo_pin_out(lo_pin_out),
      .lo_pin_oe(lo_pin_oe), .hi_pin_in(hi_pin_in), .hi_pin_out(hi_pin_out),
      .hi_pin_oe(hi_pin_oe), .chan_on(chan_on)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Shift 32 bit pairs so that stage i of lane k ends with dk[i].
   task automatic load(input logic dir, input logic [31:0] d0, input logic [31:0] d1);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         dir_cw = dir;
         if (dir) begin
            lo_pin_in = {d1[31-i], d0[31-i]};
         end else begin
            hi_pin_in = {d1[i], d0[i]};
         end
      end
      @(negedge clk);
   endtask

   // One edge with latch_en high, pushing a filler 0 into both lanes.
   task automatic latch_now();
      latch_en = 1'b1;
      lo_pin_in = 2'b00;
      hi_pin_in = 2'b00;
      @(negedge clk);
      latch_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] frame;
      repeat (3) @(negedge clk);
      chk("R1 chan_on after reset", chan_on, 64'h0);
      chk("R1 serial outs after reset", {60'h0, hi_pin_out, lo_pin_out}, 64'h0);
      rst_n = 1'b1;

      // table walk
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         load(t.dir, t.d0, t.d1);
         chk(t.dir ? "R4 oe up" : "R4 oe down", {60'h0, hi_pin_oe, lo_pin_oe},
             t.dir ? 64'hC : 64'h3);
         chk("R5 serial ends after load", {60'h0, hi_pin_out, lo_pin_out},
             {60'h0, t.d1[31], t.d0[31], t.d1[0], t.d0[0]});
         latch_now();
         chk(t.dir ? "R2 R9 frame up" : "R3 R9 frame down", chan_on, {t.d1, t.d0});
         if (t.dir)
            chk("R2 R5 high out after extra shift", {62'h0, hi_pin_out}, {62'h0, t.d1[30], t.d0[30]});
         else
            chk("R3 R5 low out after extra shift", {62'h0, lo_pin_out}, {62'h0, t.d1[1], t.d0[1]});
      end

      // R7 hold while a new frame shifts in
      frame = chan_on;
      load(1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D);
      chk("R7 bank holds during shift", chan_on, frame);
      chk("R7 chain still shifted", {60'h0, hi_pin_out, lo_pin_out}, {60'h0, 1'b0, 1'b1, 1'b1, 1'b1});

      // R8 blank overrides, release restores
      blank_n = 1'b0;
      #1;
      chk("R8 blank all on", chan_on, {64{1'b1}});
      blank_n = 1'b1;
      #1;
      chk("R8 release shows bank", chan_on, frame);

      // R6 shifting with blank low and latch_en high
      blank_n = 1'b0;
      latch_en = 1'b1;
      load(1'b0, 32'h0102_0408, 32'hF00F_3CC3);
      chk("R8 blank during shift", chan_on, {64{1'b1}});
      latch_en = 1'b0;
      blank_n = 1'b1;
      latch_now();
      chk("R6 frame unaffected by latch/blank", chan_on, {32'hF00F_3CC3, 32'h0102_0408});

      // R7 transparency lags the chain by one edge
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset mid-run", chan_on, 64'h0);
      chk("R1 serial outs mid-run reset", {60'h0, hi_pin_out, lo_pin_out}, 64'h0);
      dir_cw = 1'b1;
      latch_en = 1'b1;
      lo_pin_in = 2'b01;
      @(negedge clk);
      lo_pin_in = 2'b00;
      @(negedge clk);
      @(negedge clk);
      chk("R7 transparent lag", chan_on, 64'h2);
      latch_en = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule